// File: doc/BRIEF.md
# SPI Master with Register Port

This block is an SPI master that a processor drives through a small bank of word-addressed registers. Software writes a word to the transmit register. The block parks it in a one-word holding slot and then moves it into a shift engine. The engine clocks the word out most-significant bit first on `sclk`/`mosi` and samples `miso` at the same time. When the last clock edge of the word has gone by, the received word is placed in the receive register and a receive-ready flag is set.

A status register holds transmit-ready, shift-empty and receive-ready, sticky overrun flags for each direction, and an error summary. Each of these flags except shift-empty has an interrupt enable bit at the same position in the control register. The interrupt line is the OR of every enabled flag.

Up to sixteen active-low slave-select lines follow a mask register. They are driven low only while a force bit in the control register is set, so a chip select can stay low across several words. Word width, clock divide ratio, clock polarity, clock phase and the number of select lines are all fixed by parameters.

Top module: `spi_host_ctl`

## Requirements
- R1: After reset the status register (word address 2) reads 0x60, with bit 5 (shift empty) and bit 6 (transmit ready) set. Control (word 3) and select (word 5) read 0, every `ss_n` line is high, `irq` is low and `sclk` sits at CPOL.
- R2: A word written to word address 1 while transmit ready is set is loaded into the shifter one cycle later, as long as the shifter is idle. It goes out MSB first as 2*DATA_W `sclk` edges spaced CLK_DIV/2 clocks apart, and the first edge comes CLK_DIV/2 clocks after the load.
- R3: On the clock of the final `sclk` edge, the received word becomes readable at word address 0 and status bit 7 (receive ready) is set. A read of word 0 clears bit 7.
- R4: Status bit 6 (transmit ready) is low while the holding slot is occupied. Bit 5 (shift empty) is high only when the slot is empty and the shifter is idle. A word held during a transfer is loaded on the clock after that transfer finishes.
- R5: A write to word address 1 while transmit ready is low sets status bit 4 (transmit overrun) and the written word is discarded.
- R6: If a word completes while receive ready is set and word 0 is not read in that same cycle, status bit 3 (receive overrun) is set, the old data is kept and the new word is dropped. If a read of word 0 falls in the completion cycle, the read returns the old word, the new word is stored with receive ready still set, and no overrun is flagged.
- R7: Status bit 8 reads the OR of bits 3 and 4. Any write to word address 2 clears bits 3 and 4. An overrun raised in the same cycle as such a write still ends up set.
- R8: `irq` is the OR of status bits 3, 4, 6, 7 and 8, each ANDed with the control bit at the same position. Control reads back only bits 3, 4, 6, 7, 8 and 10.
- R9: `ss_n[n]` is low exactly when control bit 10 is set and bit n of the select register is set. Transfers have no effect on these lines.
- R10: `sclk` rests at CPOL whenever no word is shifting. With CPHA=0, `miso` is sampled on the leading edge and `mosi` changes on the trailing edge. With CPHA=1 the two edges swap roles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe; a read of word 0 clears receive ready |
| bus_addr | input | 3 | Word address: 0 receive, 1 transmit, 2 status, 3 control, 5 select |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed register (combinational) |
| irq | output | 1 | Interrupt request |
| sclk | output | 1 | SPI serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | NUM_SS | Active-low slave selects |

## Verification
Two pairs of events can land in the same clock. A word can complete on the same clock as a software read of the receive register. A receive overrun can arise on the same clock as a write to the status register. The bench's reference model predicts the exact cycle of the final `sclk` edge, and the bench issues the read or the status write on exactly that cycle. The outcome is then judged from the returned data, the status flags and the next receive read: the old word must come back, the new word must be kept with no overrun, and an overrun raised together with a clear must survive.

// File: rtl/spi_host_pkg.sv
package spi_host_pkg;

   // word addresses of the register bank
   typedef enum logic [2:0] {
      A_RXD  = 3'd0,
      A_TXD  = 3'd1,
      A_STAT = 3'd2,
      A_CTRL = 3'd3,
      A_SEL  = 3'd5
   } reg_addr_e;

   // flag positions shared by status and control
   localparam int B_ROE   = 3;
   localparam int B_TOE   = 4;
   localparam int B_TMT   = 5;
   localparam int B_TRDY  = 6;
   localparam int B_RRDY  = 7;
   localparam int B_ERR   = 8;
   localparam int B_FORCE = 10;

endpackage

// File: rtl/spi_host_shift.sv
module spi_host_shift #(
   parameter int DATA_W  = 8,
   parameter int CLK_DIV = 4,
   parameter int CPOL    = 0,
   parameter int CPHA    = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [DATA_W-1:0] tx_word,
   input  logic              miso,
   output logic              busy,
   output logic              done,
   output logic [DATA_W-1:0] rx_word,
   output logic              sclk,
   output logic              mosi
);
   localparam int HALF   = CLK_DIV / 2;
   localparam int CNT_W  = (HALF > 1) ? $clog2(HALF) : 1;
   localparam int EDGES  = 2 * DATA_W;
   localparam int EIDX_W = $clog2(EDGES);

   logic [CNT_W-1:0]  hcnt;
   logic [EIDX_W-1:0] eidx;
   logic [DATA_W-1:0] tx_sh, rx_sh;
   logic              sclk_q;
   logic              tick, lead, smp, shf;

   assign tick = busy && (hcnt == CNT_W'(HALF - 1));
   assign done = tick && (eidx == EIDX_W'(EDGES - 1));
   assign lead = ~eidx[0];

   // phase variant: which edge samples, which edge shifts
   generate
      if (CPHA == 0) begin : g_pha0
         assign smp     = tick & lead;
         assign shf     = tick & ~lead;
         assign rx_word = rx_sh;
      end else begin : g_pha1
         assign smp     = tick & ~lead;
         assign shf     = tick & lead & (eidx != '0);
         assign rx_word = {rx_sh[DATA_W-2:0], miso};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy   <= 1'b0;
         hcnt   <= '0;
         eidx   <= '0;
         tx_sh  <= '0;
         rx_sh  <= '0;
         sclk_q <= 1'(CPOL);
      end else if (start) begin
         busy   <= 1'b1;
         hcnt   <= '0;
         eidx   <= '0;
         tx_sh  <= tx_word;
         sclk_q <= 1'(CPOL);
      end else if (busy) begin
         if (tick) begin
            hcnt   <= '0;
            sclk_q <= ~sclk_q;
            eidx   <= eidx + 1'b1;
            if (done) busy <= 1'b0;
         end else begin
            hcnt <= hcnt + 1'b1;
         end
         if (smp) rx_sh <= {rx_sh[DATA_W-2:0], miso};
         if (shf) tx_sh <= {tx_sh[DATA_W-2:0], 1'b0};
      end
   end

   assign sclk = sclk_q;
   assign mosi = tx_sh[DATA_W-1];

endmodule

// File: rtl/spi_host_regs.sv
module spi_host_regs
   import spi_host_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int NUM_SS = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [2:0]        bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              irq,
   input  logic              sh_busy,
   input  logic              sh_done,
   input  logic [DATA_W-1:0] sh_rx,
   output logic              sh_start,
   output logic              hold_full,
   output logic [DATA_W-1:0] hold_word,
   output logic              force_ss,
   output logic [NUM_SS-1:0] sel_mask,
   output logic [4:0]        irq_en,
   output logic              rx_ready
);
   logic              wr_tx, wr_st, wr_ct, wr_sel, rd_rx;
   logic              tx_acc, tx_rej, rx_clash;
   logic              roe, toe;
   logic [DATA_W-1:0] rx_data;
   logic [31:0]       stat, ctrl;
   logic              unused_wd;

   assign wr_tx  = bus_wr && (bus_addr == A_TXD);
   assign wr_st  = bus_wr && (bus_addr == A_STAT);
   assign wr_ct  = bus_wr && (bus_addr == A_CTRL);
   assign wr_sel = bus_wr && (bus_addr == A_SEL);
   assign rd_rx  = bus_rd && (bus_addr == A_RXD);

   assign tx_acc   = wr_tx & ~hold_full;
   assign tx_rej   = wr_tx & hold_full;
   assign rx_clash = sh_done & rx_ready & ~rd_rx;
   assign sh_start = hold_full & ~sh_busy;
   assign unused_wd = ^bus_wdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_full <= 1'b0;
         hold_word <= '0;
         rx_ready  <= 1'b0;
         rx_data   <= '0;
         roe       <= 1'b0;
         toe       <= 1'b0;
         irq_en    <= '0;
         force_ss  <= 1'b0;
         sel_mask  <= '0;
      end else begin
         if (tx_acc) begin
            hold_full <= 1'b1;
            hold_word <= bus_wdata[DATA_W-1:0];
         end else if (sh_start) begin
            hold_full <= 1'b0;
         end
         if (sh_done && !rx_clash) begin
            rx_ready <= 1'b1;
            rx_data  <= sh_rx;
         end else if (rd_rx) begin
            rx_ready <= 1'b0;
         end
         // a flag raised in a clearing cycle survives
         roe <= (roe & ~wr_st) | rx_clash;
         toe <= (toe & ~wr_st) | tx_rej;
         if (wr_ct) begin
            irq_en   <= {bus_wdata[B_ERR], bus_wdata[B_RRDY], bus_wdata[B_TRDY],
                         bus_wdata[B_TOE], bus_wdata[B_ROE]};
            force_ss <= bus_wdata[B_FORCE];
         end
         if (wr_sel) sel_mask <= bus_wdata[NUM_SS-1:0];
      end
   end

   always_comb begin
      stat         = '0;
      stat[B_ROE]  = roe;
      stat[B_TOE]  = toe;
      stat[B_TMT]  = ~hold_full & ~sh_busy;
      stat[B_TRDY] = ~hold_full;
      stat[B_RRDY] = rx_ready;
      stat[B_ERR]  = roe | toe;
      ctrl          = '0;
      ctrl[B_ROE]   = irq_en[0];
      ctrl[B_TOE]   = irq_en[1];
      ctrl[B_TRDY]  = irq_en[2];
      ctrl[B_RRDY]  = irq_en[3];
      ctrl[B_ERR]   = irq_en[4];
      ctrl[B_FORCE] = force_ss;
   end

   assign irq = |(stat & ctrl & ~(32'd1 << B_FORCE));

   always_comb begin
      case (bus_addr)
         A_RXD:   bus_rdata = 32'(rx_data);
         A_STAT:  bus_rdata = stat;
         A_CTRL:  bus_rdata = ctrl;
         A_SEL:   bus_rdata = 32'(sel_mask);
         default: bus_rdata = '0;
      endcase
   end

endmodule

// File: rtl/spi_host_ssel.sv
module spi_host_ssel #(
   parameter int NUM_SS = 16
) (
   input  logic              force_ss,
   input  logic [NUM_SS-1:0] sel_mask,
   output logic [NUM_SS-1:0] ss_n
);
   generate
      for (genvar i = 0; i < NUM_SS; i++) begin : g_line
         assign ss_n[i] = ~(force_ss & sel_mask[i]);
      end
   endgenerate
endmodule

// File: rtl/spi_host_ctl.sv
module spi_host_ctl #(
   parameter int DATA_W  = 8,
   parameter int CLK_DIV = 4,
   parameter int CPOL    = 0,
   parameter int CPHA    = 0,
   parameter int NUM_SS  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [2:0]        bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              irq,
   output logic              sclk,
   output logic              mosi,
   input  logic              miso,
   output logic [NUM_SS-1:0] ss_n
);
   generate
      if (!(DATA_W == 8 || DATA_W == 16)) begin : g_bad_width
         $error("DATA_W must be 8 or 16");
      end
      if (CLK_DIV < 2 || (CLK_DIV % 2) != 0) begin : g_bad_div
         $error("CLK_DIV must be even and at least 2");
      end
      if (NUM_SS < 1 || NUM_SS > 16) begin : g_bad_ss
         $error("NUM_SS must be 1 to 16");
      end
      if (CPOL > 1 || CPHA > 1 || CPOL < 0 || CPHA < 0) begin : g_bad_mode
         $error("CPOL and CPHA must be 0 or 1");
      end
   endgenerate

   logic              sh_busy, sh_done, sh_start;
   logic              hold_full, force_ss, rx_ready;
   logic [DATA_W-1:0] hold_word, sh_rx;
   logic [NUM_SS-1:0] sel_mask;
   logic [4:0]        irq_en;

   spi_host_regs #(.DATA_W(DATA_W), .NUM_SS(NUM_SS)) regs_i (
      .clk(clk), .rst_n(rst_n),
      .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
      .sh_busy(sh_busy), .sh_done(sh_done), .sh_rx(sh_rx),
      .sh_start(sh_start), .hold_full(hold_full), .hold_word(hold_word),
      .force_ss(force_ss), .sel_mask(sel_mask), .irq_en(irq_en),
      .rx_ready(rx_ready)
   );

   spi_host_shift #(.DATA_W(DATA_W), .CLK_DIV(CLK_DIV), .CPOL(CPOL), .CPHA(CPHA)) shift_i (
      .clk(clk), .rst_n(rst_n), .start(sh_start), .tx_word(hold_word),
      .miso(miso), .busy(sh_busy), .done(sh_done), .rx_word(sh_rx),
      .sclk(sclk), .mosi(mosi)
   );

   spi_host_ssel #(.NUM_SS(NUM_SS)) ssel_i (
      .force_ss(force_ss), .sel_mask(sel_mask), .ss_n(ss_n)
   );

endmodule

// File: rtl/spi_host_ctl_chk.sv
module spi_host_ctl_chk #(
   parameter int CPOL   = 0,
   parameter int NUM_SS = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              sclk,
   input logic [NUM_SS-1:0] ss_n,
   input logic              irq,
   input logic              sh_busy,
   input logic              sh_done,
   input logic              hold_full,
   input logic              force_ss,
   input logic [4:0]        irq_en,
   input logic              rx_ready
);
   assert_sclk_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !sh_busy |-> (sclk == 1'(CPOL)));

   assert_ss_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !force_ss |-> (&ss_n));

   assert_hold_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_full && !sh_busy) |=> (sh_busy && !hold_full));

   assert_done_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      sh_done |=> !sh_busy);

   assert_done_rrdy_R3: assert property (@(posedge clk) disable iff (!rst_n)
      sh_done |=> rx_ready);

   assert_irq_masked_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_en == 5'd0) |-> !irq);
endmodule

bind spi_host_ctl spi_host_ctl_chk #(.CPOL(CPOL), .NUM_SS(NUM_SS)) chk_i (.*);

// File: tb/spi_host_ctl_tb_top.sv
module spi_host_ctl_tb_top;
   localparam int W    = 8;
   localparam int DIV  = 4;
   localparam int H    = DIV / 2;
   localparam int NSS  = 16;
   localparam int TOT  = 2 * W * H;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        b_wr = 1'b0, b_rd = 1'b0;
   logic [2:0]  b_addr = 3'd0;
   logic [31:0] b_wdata = '0;
   logic [31:0] rdata;
   logic        irq, sclk, mosi;
   logic        miso = 1'b0;
   logic [NSS-1:0] ss_n;

   int n_cmp = 0, n_bad = 0;
   bit finished = 0;

   always #5 clk = ~clk;

   spi_host_ctl #(.DATA_W(W), .CLK_DIV(DIV), .CPOL(0), .CPHA(0), .NUM_SS(NSS)) dut_i (
      .clk(clk), .rst_n(rst_n), .bus_wr(b_wr), .bus_rd(b_rd), .bus_addr(b_addr),
      .bus_wdata(b_wdata), .bus_rdata(rdata), .irq(irq), .sclk(sclk),
      .mosi(mosi), .miso(miso), .ss_n(ss_n)
   );

   function automatic logic [W-1:0] reply(int k);
      logic [15:0] v;
      v = 16'h3CA5 ^ 16'(k * 297);
      return v[W-1:0];
   endfunction

   task automatic check(logic [31:0] act, logic [31:0] exp, string tag);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   int m_hold = 0, m_busy = 0, m_cnt = 0, m_rrdy = 0, m_roe = 0, m_toe = 0, m_done_n = 0;
   logic [W-1:0]   m_holdw = '0, m_rx = '0;
   logic [31:0]    m_ctrl = '0;
   logic [NSS-1:0] m_sel = '0;
   logic [W-1:0]   exp_tx[$];

   function automatic logic [31:0] m_stat();
      logic [31:0] s;
      s = '0;
      s[3] = (m_roe != 0);
      s[4] = (m_toe != 0);
      s[5] = (m_hold == 0) && (m_busy == 0);
      s[6] = (m_hold == 0);
      s[7] = (m_rrdy != 0);
      s[8] = (m_roe != 0) || (m_toe != 0);
      return s;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_hold = 0; m_busy = 0; m_cnt = 0; m_rrdy = 0; m_roe = 0; m_toe = 0;
         m_ctrl = '0; m_sel = '0; m_rx = '0;
      end else begin
         bit comp, rd_rx, wst, clash, acc, rej, load;
         comp  = (m_busy != 0) && (m_cnt + 1 == TOT);
         rd_rx = b_rd && (b_addr == 3'd0);
         wst   = b_wr && (b_addr == 3'd2);
         clash = comp && (m_rrdy != 0) && !rd_rx;
         acc   = b_wr && (b_addr == 3'd1) && (m_hold == 0);
         rej   = b_wr && (b_addr == 3'd1) && (m_hold != 0);
         load  = (m_hold != 0) && (m_busy == 0);
         if (comp) begin
            if (!clash) begin m_rx = reply(m_done_n); m_rrdy = 1; end
            m_done_n++;
         end else if (rd_rx) m_rrdy = 0;
         m_roe = ((m_roe != 0) && !wst) || clash;
         m_toe = ((m_toe != 0) && !wst) || rej;
         if (load) begin
            m_busy = 1; m_cnt = 0; m_hold = 0; exp_tx.push_back(m_holdw);
         end else if (m_busy != 0) begin
            m_cnt++;
            if (comp) m_busy = 0;
         end
         if (acc) begin m_hold = 1; m_holdw = b_wdata[W-1:0]; end
         if (b_wr && b_addr == 3'd3) m_ctrl = b_wdata & 32'h0000_05D8;
         if (b_wr && b_addr == 3'd5) m_sel = b_wdata[NSS-1:0];
      end
   end

   // per-cycle comparison, away from both clock edges
   always @(negedge clk) begin
      #2;
      if (!finished) begin
         logic [NSS-1:0] ss_exp;
         logic sclk_exp;
         for (int i = 0; i < NSS; i++) ss_exp[i] = !(m_ctrl[10] && m_sel[i]);
         sclk_exp = (m_busy != 0) ? 1'((m_cnt / H) % 2) : 1'b0;
         check(32'(sclk), 32'(sclk_exp), "R10 sclk");
         check(32'(ss_n), 32'(ss_exp), "R9 ss_n");
         check(32'(irq), 32'(|(m_stat() & m_ctrl & 32'h1D8)), "R8 irq");
         if (b_rd) begin
            case (b_addr)
               3'd0: check(rdata, 32'(m_rx), "R3 rx read");
               3'd2: check(rdata, m_stat(), "R7 status read");
               3'd3: check(rdata, m_ctrl, "R8 control read");
               3'd5: check(rdata, 32'(m_sel), "R9 select read");
               default: check(rdata, 32'd0, "R1 empty read");
            endcase
         end
      end
   end

   // ---------------- SPI slave (CPOL=0, CPHA=0) ----------------
   int s_bit = 0, s_idx = 0;
   logic [W-1:0] s_cap = '0;
   initial begin
      logic [W-1:0] r;
      r = reply(0);
      miso = r[W-1];
   end
   always @(sclk) begin
      if (rst_n) begin
         if (sclk == 1'b1) s_cap = {s_cap[W-2:0], mosi};
         else begin
            logic [W-1:0] r;
            s_bit++;
            if (s_bit == W) begin
               logic [W-1:0] e;
               e = (exp_tx.size() > 0) ? exp_tx.pop_front() : 'x;
               check(32'(s_cap), 32'(e), "R2 mosi word");
               s_bit = 0;
               s_idx++;
            end
            r = reply(s_idx);
            miso = r[W-1-s_bit];
         end
      end
   end

   // ---------------- stimulus ----------------
   task automatic bus_op(bit wr, bit rd, logic [2:0] a, logic [31:0] d);
      b_wr = wr; b_rd = rd; b_addr = a; b_wdata = d;
      @(negedge clk);
      b_wr = 0; b_rd = 0;
   endtask

   task automatic rd_chk(logic [2:0] a, logic [31:0] exp, string tag);
      b_rd = 1; b_addr = a;
      #2;
      check(rdata, exp, tag);
      @(negedge clk);
      b_rd = 0;
   endtask

   task automatic wait_idle();
      while (m_busy != 0 || m_hold != 0) @(negedge clk);
   endtask

   task automatic wait_final();
      while (!(m_busy != 0 && m_cnt == TOT - 1)) @(negedge clk);
   endtask

   task automatic summary();
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      rd_chk(3'd2, 32'h60, "R1 status");
      rd_chk(3'd3, 32'h0, "R1 control");
      rd_chk(3'd5, 32'h0, "R1 select");
      // R9 forced select
      bus_op(1, 0, 3'd5, 32'h0004);
      bus_op(1, 0, 3'd3, 32'h0400);
      rd_chk(3'd5, 32'h0004, "R9 select");
      // R2/R3 single word
      bus_op(1, 0, 3'd1, 32'hA5);
      wait_idle();
      rd_chk(3'd2, 32'hE0, "R3 rrdy set");
      rd_chk(3'd0, 32'(reply(0)), "R3 rx data");
      rd_chk(3'd2, 32'h60, "R3 rrdy cleared");
      // R4/R5 back to back writes
      bus_op(1, 0, 3'd1, 32'h5A);
      bus_op(1, 0, 3'd1, 32'h11);
      rd_chk(3'd2, 32'h150, "R5 transmit overrun");
      bus_op(1, 0, 3'd1, 32'hC3);
      rd_chk(3'd2, 32'h110, "R4 holding full");
      bus_op(1, 0, 3'd2, 32'h0);
      rd_chk(3'd2, 32'h000, "R7 status cleared");
      wait_idle();
      rd_chk(3'd2, 32'h1E8, "R6 receive overrun");
      rd_chk(3'd0, 32'(reply(1)), "R6 old data kept");
      // R8 interrupt enables
      bus_op(1, 0, 3'd3, 32'hFFFF_FFFF);
      rd_chk(3'd3, 32'h5D8, "R8 control mask");
      bus_op(1, 0, 3'd2, 32'h0);
      bus_op(1, 0, 3'd3, 32'h480);
      bus_op(1, 0, 3'd1, 32'h0F);
      wait_idle();
      repeat (2) @(negedge clk);
      rd_chk(3'd0, 32'(reply(3)), "R8 rx after irq");
      // R6 read coinciding with completion
      bus_op(1, 0, 3'd1, 32'h96);
      wait_idle();
      bus_op(1, 0, 3'd1, 32'h69);
      wait_final();
      rd_chk(3'd0, 32'(reply(4)), "R6 read at completion");
      rd_chk(3'd2, 32'hE0, "R6 no overrun");
      rd_chk(3'd0, 32'(reply(5)), "R6 new word kept");
      // R7 clear coinciding with overrun
      bus_op(1, 0, 3'd1, 32'h33);
      wait_idle();
      bus_op(1, 0, 3'd1, 32'hCC);
      wait_final();
      bus_op(1, 0, 3'd2, 32'h0);
      rd_chk(3'd2, 32'h1E8, "R7 set wins over clear");
      bus_op(1, 0, 3'd2, 32'h0);
      rd_chk(3'd2, 32'hE0, "R7 cleared");
      rd_chk(3'd0, 32'(reply(6)), "R6 data kept");
      // R9 release and remask
      bus_op(1, 0, 3'd3, 32'h0);
      bus_op(1, 0, 3'd5, 32'h8001);
      bus_op(1, 0, 3'd3, 32'h400);
      rd_chk(3'd5, 32'h8001, "R9 select two lines");
      repeat (4) @(negedge clk);
      summary();
   end
endmodule